// File: doc/BRIEF.md
# Subroutine-Call Micro-Sequencer with Open-Bus Latch

This block steps a narrow slice of an 8-bit-data, 24-bit-address processor through its subroutine calls, one machine cycle per clock. It knows three calls: a 16-bit absolute call, a 24-bit long call that also changes the program bank, and a call through a 16-bit pointer table indexed by X. Every other opcode is treated as a two-cycle no-operation. On each cycle it drives one bus transfer (a read or a stack write) or no transfer at all. It also reports a cycle index and a cycle kind, so the exact bus order can be observed from outside.

A data latch holds the most recent byte that crossed the bus. When the address decoder reports that the current read address has no device behind it, the sequencer takes the latched byte in place of the read data. The long call and the indexed call place their stack pushes between operand fetches. As a result, when such a call runs from unmapped space, its later operand bytes come from the bytes it has just pushed. The long call then stays in its own bank, and the indexed call's pointer high byte equals the low byte of its return address.

Top module: `call_seq_top`

## Requirements
- R1: After a synchronous reset, PC, program bank and stack pointer take their parameter values and the latch holds 0. The cycle index is 0 and the first cycle is an opcode read at {bank, PC}.
- R2: The latch takes the byte of every mapped read and of every stack write. A mapped read returns the bus read data.
- R3: A read with `bus_mapped` low returns the latched byte and leaves the latch unchanged. Idle cycles assert neither strobe and leave the latch unchanged.
- R4: Opcode 0x20 takes 6 cycles: opcode, operand low, operand high, idle, push PC high, push PC low. After the last cycle PC = {high, low}.
- R5: Opcode 0x22 takes 8 cycles: opcode, operand low, operand high, push bank, idle, bank operand, push PC high, push PC low. After the last cycle PC = {high, low} and the bank = bank operand. When run from unmapped space, the new bank therefore equals the old bank.
- R6: Opcode 0xFC takes 8 cycles: opcode, operand low, push PC high, push PC low, operand high, idle, read target low, read target high. The target is read within the current bank at P = {high, low} + X and at P + 1, with 16-bit wrap. PC becomes {target high, target low}.
- R7: The pushed return address is the address of the call's last byte, high byte first. Each push writes at {0x00, SP} and then decrements SP by one.
- R8: The operand fetches before the final operand byte each add one to PC. The final operand fetch and all other cycles leave PC alone until the call's end load.
- R9: Any other opcode takes 2 cycles (opcode, idle) and leaves PC one past the opcode.
- R10: `bus_rd` and `bus_wr` are never high together. The cycle kind is encoded as 0 opcode, 1 operand, 2 push, 3 idle, 4 data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_idx | input | 2*DW | X index added to the indexed-call pointer |
| bus_addr | output | 3*DW | Address of the current cycle: {bank, offset} |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe (stack push) |
| bus_wdata | output | DW | Byte being pushed |
| bus_rdata | input | DW | Read data from memory |
| bus_mapped | input | 1 | Decoder flag: a device answers at bus_addr |
| pc_q | output | 2*DW | Program counter |
| pb_q | output | DW | Program bank |
| sp_q | output | 2*DW | Stack pointer |
| mdr_q | output | DW | Open-bus data latch |
| cyc_cnt | output | 3 | Machine cycle index within the instruction |
| cyc_type | output | 3 | Kind of the current cycle (encoding in R10) |

## Verification
The calls are first run entirely from mapped memory. A nonzero X and a pointer sum that reaches 0xFFFF separate the correct P and P+1 addressing, including its 16-bit wrap, from variants that drop X or carry into the bank. Each call kind is then entered in unmapped space with the latch preloaded to its own opcode. This is done by landing the preceding long call so that its return-address low byte equals that opcode. These runs separate the interleaved push order from a straightforward fetch order, because bank byte, pointer high byte and pointer contents then differ from the opcode. A behavioural model in the bench predicts every cycle's kind, address, strobes, written byte and latch value.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam logic [7:0] OPC_CALL_ABS  = 8'h20;
  localparam logic [7:0] OPC_CALL_LONG = 8'h22;
  localparam logic [7:0] OPC_CALL_IND  = 8'hFC;

  typedef enum logic [2:0] {
    CK_OPCODE  = 3'd0,
    CK_OPERAND = 3'd1,
    CK_PUSH    = 3'd2,
    CK_IDLE    = 3'd3,
    CK_READ    = 3'd4
  } cyc_kind_e;

  typedef enum logic [2:0] {
    AS_NONE, AS_PC, AS_STACK, AS_PTR, AS_PTR1
  } addr_sel_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_OP, RD_LO, RD_HI, RD_BK, RD_TLO
  } rd_dst_e;

  typedef enum logic [1:0] {
    PS_NONE, PS_PB, PS_PCH, PS_PCL
  } push_sel_e;

  typedef enum logic [1:0] {
    LD_NONE, LD_ABS, LD_LONG, LD_IND
  } load_e;

  typedef struct packed {
    cyc_kind_e kind;
    addr_sel_e asel;
    rd_dst_e   dst;
    push_sel_e psel;
    logic      pc_inc;
    logic      mk_ptr;
    load_e     load;
    logic      last;
  } uop_t;

endpackage

// File: rtl/cs_ucode.sv
module cs_ucode
  import cs_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 3
) (
  input  logic [CW-1:0] cyc,
  input  logic [DW-1:0] op,
  output uop_t          uop
);

  function automatic uop_t mk(cyc_kind_e k, addr_sel_e a, rd_dst_e d,
                              push_sel_e p, logic inc, logic ptr,
                              load_e ld, logic fin);
    uop_t u;
    u.kind   = k;
    u.asel   = a;
    u.dst    = d;
    u.psel   = p;
    u.pc_inc = inc;
    u.mk_ptr = ptr;
    u.load   = ld;
    u.last   = fin;
    return u;
  endfunction

  localparam uop_t U_IDLE = '{kind: CK_IDLE, asel: AS_NONE, dst: RD_NONE,
                              psel: PS_NONE, pc_inc: 1'b0, mk_ptr: 1'b0,
                              load: LD_NONE, last: 1'b0};

  always_comb begin
    uop = U_IDLE;
    if (cyc == '0) begin
      uop = mk(CK_OPCODE, AS_PC, RD_OP, PS_NONE, 1'b1, 1'b0, LD_NONE, 1'b0);
    end else if (op == DW'(OPC_CALL_ABS)) begin
      unique case (cyc)
        CW'(1): uop = mk(CK_OPERAND, AS_PC, RD_LO, PS_NONE, 1'b1, 1'b0, LD_NONE, 1'b0);
        CW'(2): uop = mk(CK_OPERAND, AS_PC, RD_HI, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(3): uop = U_IDLE;
        CW'(4): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PCH, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(5): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PCL, 1'b0, 1'b0, LD_ABS, 1'b1);
        default: uop = mk(CK_IDLE, AS_NONE, RD_NONE, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b1);
      endcase
    end else if (op == DW'(OPC_CALL_LONG)) begin
      unique case (cyc)
        CW'(1): uop = mk(CK_OPERAND, AS_PC, RD_LO, PS_NONE, 1'b1, 1'b0, LD_NONE, 1'b0);
        CW'(2): uop = mk(CK_OPERAND, AS_PC, RD_HI, PS_NONE, 1'b1, 1'b0, LD_NONE, 1'b0);
        CW'(3): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PB, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(4): uop = U_IDLE;
        CW'(5): uop = mk(CK_OPERAND, AS_PC, RD_BK, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(6): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PCH, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(7): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PCL, 1'b0, 1'b0, LD_LONG, 1'b1);
        default: uop = mk(CK_IDLE, AS_NONE, RD_NONE, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b1);
      endcase
    end else if (op == DW'(OPC_CALL_IND)) begin
      unique case (cyc)
        CW'(1): uop = mk(CK_OPERAND, AS_PC, RD_LO, PS_NONE, 1'b1, 1'b0, LD_NONE, 1'b0);
        CW'(2): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PCH, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(3): uop = mk(CK_PUSH, AS_STACK, RD_NONE, PS_PCL, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(4): uop = mk(CK_OPERAND, AS_PC, RD_HI, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(5): uop = mk(CK_IDLE, AS_NONE, RD_NONE, PS_NONE, 1'b0, 1'b1, LD_NONE, 1'b0);
        CW'(6): uop = mk(CK_READ, AS_PTR, RD_TLO, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b0);
        CW'(7): uop = mk(CK_READ, AS_PTR1, RD_NONE, PS_NONE, 1'b0, 1'b0, LD_IND, 1'b1);
        default: uop = mk(CK_IDLE, AS_NONE, RD_NONE, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b1);
      endcase
    end else begin
      // unsupported opcode: one idle cycle, then done
      uop = mk(CK_IDLE, AS_NONE, RD_NONE, PS_NONE, 1'b0, 1'b0, LD_NONE, 1'b1);
    end
  end

endmodule

// File: rtl/cs_mdr.sv
module cs_mdr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          mapped,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] din,
  output logic [DW-1:0] mdr
);

  // byte seen by the core: memory when mapped, stale latch otherwise
  assign din = mapped ? rdata : mdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdr <= '0;
    end else if (wr_en) begin
      mdr <= wdata;
    end else if (rd_en) begin
      mdr <= din;
    end
  end

  assert_mdr_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mapped && !wr_en) |=> (mdr == $past(rdata)));

  assert_mdr_push_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mdr == $past(wdata)));

  assert_mdr_openbus_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped && !wr_en) |=> $stable(mdr));

  assert_mdr_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |=> $stable(mdr));

endmodule

// File: rtl/call_seq_top.sv
module call_seq_top
  import cs_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] RESET_PB = '0,
  parameter logic [2*DW-1:0] RESET_PC = '0,
  parameter logic [2*DW-1:0] RESET_SP = {{DW{1'b0}}, {DW{1'b1}}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*DW-1:0]   x_idx,
  output logic [3*DW-1:0]   bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_mapped,
  output logic [2*DW-1:0]   pc_q,
  output logic [DW-1:0]     pb_q,
  output logic [2*DW-1:0]   sp_q,
  output logic [DW-1:0]     mdr_q,
  output logic [2:0]        cyc_cnt,
  output logic [2:0]        cyc_type
);

  localparam int PW = 2 * DW;
  localparam int AW = 3 * DW;
  localparam int CW = 3;

  uop_t            uop;
  logic [DW-1:0]   din;
  logic [DW-1:0]   op_q, lo_q, hi_q, bk_q, tlo_q;
  logic [PW-1:0]   ptr_q;
  logic [CW-1:0]   cyc_q;

  cs_ucode #(.DW(DW), .CW(CW)) u_dec (
    .cyc (cyc_q),
    .op  (op_q),
    .uop (uop)
  );

  cs_mdr #(.DW(DW)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (bus_rd),
    .wr_en  (bus_wr),
    .mapped (bus_mapped),
    .rdata  (bus_rdata),
    .wdata  (bus_wdata),
    .din    (din),
    .mdr    (mdr_q)
  );

  always_comb begin
    unique case (uop.asel)
      AS_PC:    bus_addr = {pb_q, pc_q};
      AS_STACK: bus_addr = {{DW{1'b0}}, sp_q};
      AS_PTR:   bus_addr = {pb_q, ptr_q};
      AS_PTR1:  bus_addr = {pb_q, ptr_q + PW'(1)};
      default:  bus_addr = '0;
    endcase
  end

  always_comb begin
    unique case (uop.psel)
      PS_PB:   bus_wdata = pb_q;
      PS_PCH:  bus_wdata = pc_q[PW-1:DW];
      PS_PCL:  bus_wdata = pc_q[DW-1:0];
      default: bus_wdata = '0;
    endcase
  end

  assign bus_rd   = (uop.kind == CK_OPCODE) || (uop.kind == CK_OPERAND) ||
                    (uop.kind == CK_READ);
  assign bus_wr   = (uop.kind == CK_PUSH);
  assign cyc_type = uop.kind;
  assign cyc_cnt  = cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      pb_q  <= RESET_PB;
      sp_q  <= RESET_SP;
      cyc_q <= '0;
      op_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      bk_q  <= '0;
      tlo_q <= '0;
      ptr_q <= '0;
    end else begin
      cyc_q <= uop.last ? '0 : cyc_q + CW'(1);
      if (uop.pc_inc) pc_q <= pc_q + PW'(1);
      if (bus_wr)     sp_q <= sp_q - PW'(1);
      unique case (uop.dst)
        RD_OP:   op_q  <= din;
        RD_LO:   lo_q  <= din;
        RD_HI:   hi_q  <= din;
        RD_BK:   bk_q  <= din;
        RD_TLO:  tlo_q <= din;
        default: ;
      endcase
      if (uop.mk_ptr) ptr_q <= {hi_q, lo_q} + x_idx;
      unique case (uop.load)
        LD_ABS:  pc_q <= {hi_q, lo_q};
        LD_LONG: begin
          pc_q <= {hi_q, lo_q};
          pb_q <= bk_q;
        end
        LD_IND:  pc_q <= {din, tlo_q};
        default: ;
      endcase
    end
  end

  assert_first_opcode_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc_cnt == 3'd0) |-> (cyc_type == 3'd0 && bus_rd && bus_addr == {pb_q, pc_q}));

  assert_two_cycle_min_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc_cnt == 3'd0) |=> (cyc_cnt == 3'd1));

  assert_idle_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == 3'd3) |-> (!bus_rd && !bus_wr));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  assert_push_sp_step_R7: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (sp_q == $past(sp_q) - PW'(1)));

  assert_push_bank0_R7: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_addr[AW-1:PW] == '0 && bus_addr[PW-1:0] == sp_q));

  assert_sp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(sp_q));

endmodule

// File: tb/tb_call_seq_top.sv
module tb_call_seq_top;

  typedef struct packed {
    logic [2:0]  kind;
    logic [2:0]  cnt;
    logic        rd;
    logic        wr;
    logic [23:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  mdr_before;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] x_idx;
  logic [23:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_mapped;
  logic [15:0] pc_q, sp_q;
  logic [7:0]  pb_q, mdr_q;
  logic [2:0]  cyc_cnt, cyc_type;

  always #5 clk = ~clk;

  call_seq_top #(
    .DW(8), .RESET_PB(8'h01), .RESET_PC(16'h8000), .RESET_SP(16'h01FF)
  ) dut (
    .clk(clk), .rst(rst), .x_idx(x_idx),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_mapped(bus_mapped),
    .pc_q(pc_q), .pb_q(pb_q), .sp_q(sp_q), .mdr_q(mdr_q),
    .cyc_cnt(cyc_cnt), .cyc_type(cyc_type)
  );

  int total = 0;
  int bad   = 0;
  int ticks = 0;
  bit done  = 1'b0;

  logic [7:0]  mem [logic [23:0]];
  logic [15:0] m_pc, m_sp;
  logic [7:0]  m_pb, m_mdr, m_op;
  int          k;
  exp_t        q[$];
  string       tag;

  // bank bit 2 set means nothing is mapped there (bank 0x04 is open bus)
  function automatic logic is_mapped(input logic [23:0] a);
    return !a[18];
  endfunction

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    if (mem.exists(a)) return mem[a];
    if (a[23:16] == 8'h01) return 8'hEA;
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic m_read(input logic [2:0] kd, input logic [23:0] a,
                        output logic [7:0] v);
    exp_t e;
    e.kind = kd; e.cnt = k[2:0]; e.rd = 1'b1; e.wr = 1'b0;
    e.addr = a; e.wdata = 8'h00; e.mdr_before = m_mdr;
    v = is_mapped(a) ? mem_val(a) : m_mdr;
    m_mdr = v;
    q.push_back(e);
    k++;
  endtask

  task automatic m_push(input logic [7:0] b);
    exp_t e;
    e.kind = 3'd2; e.cnt = k[2:0]; e.rd = 1'b0; e.wr = 1'b1;
    e.addr = {8'h00, m_sp}; e.wdata = b; e.mdr_before = m_mdr;
    mem[{8'h00, m_sp}] = b;
    m_mdr = b;
    m_sp  = m_sp - 16'd1;
    q.push_back(e);
    k++;
  endtask

  task automatic m_idle();
    exp_t e;
    e.kind = 3'd3; e.cnt = k[2:0]; e.rd = 1'b0; e.wr = 1'b0;
    e.addr = 24'h0; e.wdata = 8'h00; e.mdr_before = m_mdr;
    q.push_back(e);
    k++;
  endtask

  // expected bus cycles of one whole instruction, from the requirements
  task automatic build();
    logic [7:0]  lo, hi, bk, tl, th;
    logic [15:0] ptr;
    k = 0;
    m_read(3'd0, {m_pb, m_pc}, m_op);
    m_pc = m_pc + 16'd1;
    case (m_op)
      8'h20: begin
        m_read(3'd1, {m_pb, m_pc}, lo); m_pc = m_pc + 16'd1;
        m_read(3'd1, {m_pb, m_pc}, hi);
        m_idle();
        m_push(m_pc[15:8]); m_push(m_pc[7:0]);
        m_pc = {hi, lo};
      end
      8'h22: begin
        m_read(3'd1, {m_pb, m_pc}, lo); m_pc = m_pc + 16'd1;
        m_read(3'd1, {m_pb, m_pc}, hi); m_pc = m_pc + 16'd1;
        m_push(m_pb);
        m_idle();
        m_read(3'd1, {m_pb, m_pc}, bk);
        m_push(m_pc[15:8]); m_push(m_pc[7:0]);
        m_pc = {hi, lo}; m_pb = bk;
      end
      8'hFC: begin
        m_read(3'd1, {m_pb, m_pc}, lo); m_pc = m_pc + 16'd1;
        m_push(m_pc[15:8]); m_push(m_pc[7:0]);
        m_read(3'd1, {m_pb, m_pc}, hi);
        m_idle();
        ptr = {hi, lo} + x_idx;
        m_read(3'd4, {m_pb, ptr}, tl);
        m_read(3'd4, {m_pb, ptr + 16'd1}, th);
        m_pc = {th, tl};
      end
      default: m_idle();
    endcase
  endtask

  // compare the current cycle at the negedge, then present read data
  task automatic cycle_now();
    exp_t e;
    if (q.size() == 0) begin
      chk(pc_q == m_pc, "R8", "pc at boundary", pc_q, m_pc);
      chk(pb_q == m_pb, "R5", "bank at boundary", pb_q, m_pb);
      chk(sp_q == m_sp, "R7", "sp at boundary", sp_q, m_sp);
      build();
    end
    e = q.pop_front();
    case (m_op)
      8'h20:   tag = "R4";
      8'h22:   tag = "R5";
      8'hFC:   tag = "R6";
      default: tag = "R9";
    endcase
    if (e.cnt == 3'd0) tag = "R1";
    chk(cyc_type == e.kind, tag, "cycle kind (R10 code)", cyc_type, e.kind);
    chk(cyc_cnt == e.cnt, tag, "cycle index", cyc_cnt, e.cnt);
    chk(bus_rd == e.rd && bus_wr == e.wr, "R10", "strobes",
        {bus_rd, bus_wr}, {e.rd, e.wr});
    if (e.rd || e.wr)
      chk(bus_addr == e.addr, tag, "bus address", bus_addr, e.addr);
    if (e.wr)
      chk(bus_wdata == e.wdata, "R7", "pushed byte", bus_wdata, e.wdata);
    chk(mdr_q == e.mdr_before, "R2", "latch value", mdr_q, e.mdr_before);
    bus_rdata  = mem_val(bus_addr);
    bus_mapped = is_mapped(bus_addr);
  endtask

  task automatic reset_and_check();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 16'h8000; m_pb = 8'h01; m_sp = 16'h01FF; m_mdr = 8'h00;
    m_op = 8'h00;
    q.delete();
    chk(pc_q == 16'h8000 && pb_q == 8'h01, "R1", "reset pc/bank",
        {pb_q, pc_q}, 24'h018000);
    chk(sp_q == 16'h01FF, "R1", "reset sp", sp_q, 16'h01FF);
    chk(mdr_q == 8'h00 && cyc_cnt == 3'd0, "R1", "reset latch/index",
        {mdr_q, 5'd0, cyc_cnt}, 0);
    chk(cyc_type == 3'd0 && bus_rd && bus_addr == 24'h018000, "R1",
        "first opcode fetch", bus_addr, 24'h018000);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      cycle_now();
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", ticks, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    x_idx = 16'h0004;
    bus_rdata = 8'h00;
    bus_mapped = 1'b1;

    // Scenario A: all calls from mapped memory, X = 4, pointer wrap
    mem.delete();
    mem[24'h018000] = 8'h20; mem[24'h018001] = 8'h00; mem[24'h018002] = 8'h90;
    mem[24'h019000] = 8'hFC; mem[24'h019001] = 8'h10; mem[24'h019002] = 8'hA0;
    mem[24'h01A014] = 8'h00; mem[24'h01A015] = 8'hB0;
    mem[24'h01B000] = 8'h22; mem[24'h01B001] = 8'h00; mem[24'h01B002] = 8'hC0;
    mem[24'h01B003] = 8'h01;
    mem[24'h01C000] = 8'hFC; mem[24'h01C001] = 8'hFB; mem[24'h01C002] = 8'hFF;
    mem[24'h01FFFF] = 8'h00; mem[24'h010000] = 8'hD0;
    reset_and_check();
    run(6);
    chk(pc_q == 16'h9000 && sp_q == 16'h01FD, "R4", "abs call target/sp",
        {pc_q, sp_q}, {16'h9000, 16'h01FD});
    run(8);
    chk(pc_q == 16'hB000 && mdr_q == 8'hB0, "R6", "indexed call X offset",
        {pc_q, mdr_q}, {16'hB000, 8'hB0});
    run(16);
    chk(pc_q == 16'hD000 && pb_q == 8'h01, "R6", "pointer wrap FFFF->0000",
        {pb_q, pc_q}, 24'h01D000);
    chk(sp_q == 16'h01F6, "R7", "sp after four calls", sp_q, 16'h01F6);
    run(4);
    chk(pc_q == 16'hD002 && mdr_q == 8'hEA, "R9", "two nops", {pc_q, mdr_q},
        {16'hD002, 8'hEA});

    // Scenario B: long call executed from open bus (latch = 0x22)
    x_idx = 16'h0000;
    mem.delete();
    mem[24'h018000] = 8'h20; mem[24'h018001] = 8'h1F; mem[24'h018002] = 8'h80;
    mem[24'h01801F] = 8'h22; mem[24'h018020] = 8'h00; mem[24'h018021] = 8'h30;
    mem[24'h018022] = 8'h04;
    reset_and_check();
    run(14);
    chk(mdr_q == 8'h22 && pb_q == 8'h04, "R7", "return low byte in latch",
        {pb_q, mdr_q}, {8'h04, 8'h22});
    run(8);
    chk(pc_q == 16'h2222 && pb_q == 8'h04, "R5", "open-bus long call stays in bank",
        {pb_q, pc_q}, 24'h042222);
    chk(mdr_q == 8'h03 && sp_q == 16'h01F7, "R3", "latch/sp after open-bus long call",
        {mdr_q, sp_q}, {8'h03, 16'h01F7});
    chk(mem_val(24'h0001FA) == 8'h04 && mem_val(24'h0001F8) == 8'h03, "R7",
        "stack bytes in bank 0", {mem_val(24'h0001FA), mem_val(24'h0001F8)},
        16'h0403);

    // Scenario C: indexed call from open bus (latch = 0xFC)
    mem.delete();
    mem[24'h018000] = 8'h20; mem[24'h018001] = 8'hF9; mem[24'h018002] = 8'h80;
    mem[24'h0180F9] = 8'h22; mem[24'h0180FA] = 8'h78; mem[24'h0180FB] = 8'h56;
    mem[24'h0180FC] = 8'h04;
    reset_and_check();
    run(22);
    chk(pc_q == 16'h7A7A && pb_q == 8'h04, "R6", "open-bus indexed call target",
        {pb_q, pc_q}, 24'h047A7A);
    chk(mdr_q == 8'h7A && sp_q == 16'h01F8, "R3", "latch/sp after open-bus indexed call",
        {mdr_q, sp_q}, {8'h7A, 16'h01F8});

    // Scenario D: absolute call from open bus (latch = 0x20)
    mem.delete();
    mem[24'h018000] = 8'h20; mem[24'h018001] = 8'h1D; mem[24'h018002] = 8'h80;
    mem[24'h01801D] = 8'h22; mem[24'h01801E] = 8'h34; mem[24'h01801F] = 8'h12;
    mem[24'h018020] = 8'h04;
    reset_and_check();
    run(20);
    chk(pc_q == 16'h2020 && pb_q == 8'h04, "R4", "open-bus abs call target",
        {pb_q, pc_q}, 24'h042020);
    chk(mdr_q == 8'h36 && sp_q == 16'h01F8, "R2", "latch holds last push",
        {mdr_q, sp_q}, {8'h36, 16'h01F8});
    run(4);
    chk(pc_q == 16'h2022 && mdr_q == 8'h36, "R9", "open-bus nop keeps latch",
        {pc_q, mdr_q}, {16'h2022, 8'h36});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule